// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers interrupt request lines from eight sources, folds them onto six service vectors and chooses at most one vector to take at each instruction boundary. The chosen vector is turned into a fixed 16-bit program address, placed 8 bytes apart from 0003H upward. Two preemption levels are tracked with one in-service flag per level. A high-priority vector may interrupt a low-priority routine. Nothing interrupts a high-priority routine.

The sequencer of the processor drives `insn_end` once per completed instruction and drives `ret_irq` when an interrupt routine returns. When `taken` pulses, the sequencer loads `vec_addr` into the program counter. Stacking the return address and raising the request flags inside peripherals are handled elsewhere.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While reset is active and after it is released, `taken` is 0, `vec_addr` is 0000H and both `in_svc_hi` and `in_svc_lo` are 0, until a vector is first taken.
- R2: Vector k (k = 0..5) has the address 0003H + 8*k, so the vectors sit at 0003H, 000BH, 0013H, 001BH, 0023H and 002BH. Source 0 is served at 0003H.
- R3: Source bit s of `irq_req` feeds vector s for s = 0..3. Sources 4 and 5 both feed vector 4. Sources 6 and 7 both feed vector 5. Any one source of a shared vector is enough to raise it.
- R4: A vector is taken only on a clock edge where `insn_end` is 1. `taken` is 1 for that one cycle. `vec_addr` and the in-service flag are updated on the same edge, so they are visible in the cycle after the strobe.
- R5: A pending enabled vector whose bit in `vec_prio` is 1 (high) wins over every low one, whatever their addresses.
- R6: Among pending enabled vectors of the same level, the lowest vector index (lowest address) wins.
- R7: A high vector is taken while only the low routine is in service, and it sets `in_svc_hi`. A low vector is never taken while `in_svc_lo` is 1.
- R8: While `in_svc_hi` is 1, no vector is taken.
- R9: A `ret_irq` edge clears `in_svc_hi` if it is set, and clears `in_svc_lo` otherwise.
- R10: With `glob_en` at 0, no vector is taken. Setting `glob_en` to 1 again restores the per-vector enables unchanged.
- R11: A vector whose bit in `vec_en` is 0 is never taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Per-source request lines |
| vec_en | input | 6 | Per-vector enable, bit k for vector k |
| glob_en | input | 1 | Global enable |
| vec_prio | input | 6 | Per-vector level, 1 = high |
| insn_end | input | 1 | Instruction-boundary strobe |
| ret_irq | input | 1 | Return-from-interrupt strobe |
| taken | output | 1 | One-cycle pulse when a vector is taken |
| vec_addr | output | 16 | Address of the last vector taken |
| in_svc_hi | output | 1 | High-level routine in service |
| in_svc_lo | output | 1 | Low-level routine in service |

## Verification
All outputs are registered. The effect of inputs that are applied in one cycle appears one clock edge later: the take pulse, the new address and the changed in-service flags. There is never a longer path. Every stimulus cycle pushes one expected tuple into a queue. The monitor pops that tuple shortly after the next rising edge, so it compares exactly one edge after the inputs were applied. Cases that must not take a vector check that `taken` stays 0 and that the address and flags keep their previous values.

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int N_SRC = 8,
  parameter int N_VEC = 6,
  parameter int MAP_W = 3,
  parameter logic [N_SRC*MAP_W-1:0] SRC_VEC = 24'b101_101_100_100_011_010_001_000,
  parameter logic [15:0] BASE = 16'h0003,
  parameter logic [15:0] STRIDE = 16'h0008
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_VEC-1:0] vec_en,
  input  logic             glob_en,
  input  logic [N_VEC-1:0] vec_prio,
  input  logic             insn_end,
  input  logic             ret_irq,
  output logic             taken,
  output logic [15:0]      vec_addr,
  output logic             in_svc_hi,
  output logic             in_svc_lo
);

  logic [N_VEC-1:0] vreq, live, hi_cand, lo_cand;
  logic [MAP_W-1:0] hi_idx, lo_idx, win_idx;
  logic             grant, grant_hi;

  always_comb begin
    vreq = '0;
    for (int s = 0; s < N_SRC; s++)
      if (irq_req[s]) vreq[SRC_VEC[s*MAP_W +: MAP_W]] = 1'b1;
  end

  assign live    = vreq & vec_en & {N_VEC{glob_en}};
  assign hi_cand = live & vec_prio;
  assign lo_cand = live & ~vec_prio;

  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int k = N_VEC - 1; k >= 0; k--) begin
      if (hi_cand[k]) hi_idx = MAP_W'(k);
      if (lo_cand[k]) lo_idx = MAP_W'(k);
    end
  end

  assign grant_hi = !in_svc_hi && |hi_cand;
  assign grant    = insn_end && (grant_hi || (!in_svc_hi && !in_svc_lo && |lo_cand));
  assign win_idx  = grant_hi ? hi_idx : lo_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken     <= 1'b0;
      vec_addr  <= 16'h0000;
      in_svc_hi <= 1'b0;
      in_svc_lo <= 1'b0;
    end else begin
      taken <= grant;
      if (grant) vec_addr <= BASE + 16'(win_idx) * STRIDE;
      if (grant && grant_hi)      in_svc_hi <= 1'b1;
      else if (ret_irq)           in_svc_hi <= 1'b0;
      if (grant && !grant_hi)     in_svc_lo <= 1'b1;
      else if (ret_irq && !in_svc_hi) in_svc_lo <= 1'b0;
    end
  end

  assert_take_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> $past(insn_end));

  assert_hi_not_preempted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc_hi |=> !taken);

  assert_hi_flag_with_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_svc_hi) |-> taken);

  assert_lo_flag_with_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_svc_lo) |-> taken);

  assert_ret_clears_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_irq && in_svc_hi) |=> !in_svc_hi);

  assert_ret_clears_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_irq && !in_svc_hi) |=> !in_svc_lo);

  assert_global_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !taken);

endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  irq_req = 0;
  logic [5:0]  vec_en = 6'h3F;
  logic        glob_en = 1;
  logic [5:0]  vec_prio = 0;
  logic        insn_end = 0;
  logic        ret_irq = 0;
  logic        taken;
  logic [15:0] vec_addr;
  logic        in_svc_hi, in_svc_lo;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [18:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .vec_en(vec_en),
    .glob_en(glob_en), .vec_prio(vec_prio), .insn_end(insn_end),
    .ret_irq(ret_irq), .taken(taken), .vec_addr(vec_addr),
    .in_svc_hi(in_svc_hi), .in_svc_lo(in_svc_lo));

  task automatic compare(input logic [18:0] exp, input string tag);
    logic [18:0] act;
    act = {taken, vec_addr, in_svc_hi, in_svc_lo};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got taken=%b addr=%h hi=%b lo=%b, expected taken=%b addr=%h hi=%b lo=%b",
               tag, act[18], act[17:2], act[1], act[0], exp[18], exp[17:2], exp[1], exp[0]);
    end
  endtask

  task automatic step(input logic [7:0] src, input logic [5:0] en, input logic g,
                      input logic [5:0] pr, input logic ie, input logic rt,
                      input logic e_take, input logic [15:0] e_addr,
                      input logic e_hi, input logic e_lo, input string tag);
    @(negedge clk);
    irq_req = src; vec_en = en; glob_en = g; vec_prio = pr;
    insn_end = ie; ret_irq = rt;
    exp_q.push_back({e_take, e_addr, e_hi, e_lo});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #5 compare({1'b0, 16'h0000, 1'b0, 1'b0}, "R1 reset state");
    @(negedge clk); rst_n = 1;
    step(8'h01, 6'h3F, 1, 6'h00, 1, 0, 1, 16'h0003, 0, 1, "R2 src0 at 0003H");
    step(8'h00, 6'h3F, 1, 6'h00, 0, 0, 0, 16'h0003, 0, 1, "R4 one-cycle pulse");
    step(8'h04, 6'h3F, 1, 6'h00, 1, 0, 0, 16'h0003, 0, 1, "R7 low cannot preempt low");
    step(8'h04, 6'h3F, 1, 6'h04, 1, 0, 1, 16'h0013, 1, 1, "R7 high preempts low");
    step(8'h01, 6'h3F, 1, 6'h3F, 1, 0, 0, 16'h0013, 1, 1, "R8 high not preempted");
    step(8'h00, 6'h3F, 1, 6'h00, 0, 1, 0, 16'h0013, 0, 1, "R9 return clears high first");
    step(8'h00, 6'h3F, 1, 6'h00, 0, 1, 0, 16'h0013, 0, 0, "R9 return clears low");
    step(8'hB8, 6'h3F, 1, 6'h00, 1, 0, 1, 16'h001B, 0, 1, "R6 lowest index wins");
    step(8'h00, 6'h3F, 1, 6'h00, 0, 1, 0, 16'h001B, 0, 0, "R9 return");
    step(8'h81, 6'h3F, 1, 6'h20, 1, 0, 1, 16'h002B, 1, 0, "R5 high beats lower address");
    step(8'h00, 6'h3F, 1, 6'h00, 0, 1, 0, 16'h002B, 0, 0, "R9 return from high");
    step(8'h20, 6'h3F, 1, 6'h00, 1, 0, 1, 16'h0023, 0, 1, "R3 src5 shares vector 4");
    step(8'h00, 6'h3F, 1, 6'h00, 0, 1, 0, 16'h0023, 0, 0, "R9 return");
    step(8'h40, 6'h3F, 1, 6'h00, 0, 0, 0, 16'h0023, 0, 0, "R4 no take without boundary");
    step(8'h40, 6'h3F, 0, 6'h00, 1, 0, 0, 16'h0023, 0, 0, "R10 global mask");
    step(8'h40, 6'h3F, 1, 6'h00, 1, 0, 1, 16'h002B, 0, 1, "R10 enables restored, R3 src6");
    step(8'h00, 6'h3F, 1, 6'h00, 0, 1, 0, 16'h002B, 0, 0, "R9 return");
    step(8'h02, 6'h3D, 1, 6'h00, 1, 0, 0, 16'h002B, 0, 0, "R11 vector disabled");
    step(8'h02, 6'h3F, 1, 6'h00, 1, 0, 1, 16'h000B, 0, 1, "R2 vector 1 at 000BH");
    step(8'h10, 6'h3F, 1, 6'h10, 1, 0, 1, 16'h0023, 1, 1, "R3 src4 high at 0023H");
    step(8'h00, 6'h3F, 1, 6'h00, 0, 0, 0, 16'h0023, 1, 1, "R8 hold");
    @(negedge clk); insn_end = 0; ret_irq = 0; irq_req = 0; rst_n = 0;
    @(posedge clk); #5 compare({1'b0, 16'h0000, 1'b0, 1'b0}, "R1 reset clears state");
    wait (exp_q.size() == 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule